// File: doc/BRIEF.md
# Load/AND Pipeline Hazard Controller

This block resolves data hazards for a five-stage in-order pipeline whose instruction set holds only two instructions: a word load and a register-register AND. The datapath gives it the instruction word that sits in the fetch/decode register. From each word it keeps its own record of the hazard-relevant fields as the instruction moves through the execute, memory and write-back stages. Each cycle it compares these records and drives two outputs. The first is a pair of operand-source selects for the execute-stage ALU input multiplexers. The second is a stall signal.

The stall signal works in three ways at once. The datapath uses it to hold the program counter and the fetch/decode register. The block clears its own execute-stage record in the same edge, and the datapath clears the control bits of its decode/execute register to match. The register file writes in the first half of a cycle and reads in the second half, so a value in write-back is already visible to the instruction being decoded. The block never forwards into decode.

Top module: `lwand_hazard_ctrl`

## Requirements
- R1: While reset is low at a clock edge, every stage record is cleared. After reset, with no valid decode input, stall is 0 and both selects are 2'b00.
- R2: Decode uses these fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0]. Opcode 6'b100011 is the load, whose destination is rt. Opcode 6'b000000 with funct 6'b100100 is the AND, whose destination is rd. Any other word, or a word offered with ifid_valid low, is a bubble: it has no sources and no destination, and it never causes forwarding or a stall. When no forwarding applies, a select is 2'b00 (register file).
- R3: An operand select is 2'b10 when the memory stage holds an AND whose destination equals that operand's source register in the execute stage.
- R4: An operand select is 2'b01 when the write-back stage holds a load or an AND whose destination equals that operand's source, and R3 does not apply.
- R5: When both the memory stage and the write-back stage match the same source, the memory-stage value (2'b10) wins.
- R6: A destination of register 0 never produces forwarding or a stall.
- R7: The rt field of a load is only a destination. It is never compared as a source, so the second select of a load in execute stays 2'b00 and a load whose rt matches never stalls.
- R8: stall is 1 in the same cycle in which the execute stage holds a load and the decoded instruction reads its destination: the rs of a load, or the rs or rt of an AND.
- R9: A stall makes the execute stage empty in the next cycle. The held instruction is then re-evaluated without a stall, and one cycle later it takes the loaded value through select 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ifid_valid | input | 1 | Fetch/decode register holds an instruction |
| ifid_instr | input | 32 | Instruction word in the fetch/decode register |
| stall | output | 1 | Hold PC and fetch/decode, insert a bubble into execute |
| fwd_a_sel | output | 2 | First ALU operand source: 00 regfile, 01 write-back, 10 memory |
| fwd_b_sel | output | 2 | Second ALU operand source, same coding |

## Verification
Forwarding and the load-use stall are raised in the same cycle when a load sits in execute ahead of a dependent instruction in decode, while an older AND in memory or write-back feeds the load's own base register. The bench sets up this case in directed sequences: an AND, then a load that reads it, then an AND that reads the load. It also reaches the case often in a long random stream that draws from only four registers. A behavioural model of the stage history predicts stall and both selects on every cycle. The held instruction is replayed whenever the model predicts a stall, so a mismatch in either function, or in the bubble that follows, shows up at the ports.

// File: rtl/lwand_hz_pkg.sv
// Package: shared types for the load/AND hazard controller.
// Assumes 32 registers and a single-issue pipeline.
package lwand_hz_pkg;

    localparam int REG_W = 5;

    // Operand source coding consumed by the datapath multiplexers.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MEMWB   = 2'b01,
        SRC_EXMEM   = 2'b10
    } fwd_src_e;

    // Hazard-relevant record of one instruction.
    typedef struct packed {
        logic             valid;
        logic             is_load;
        logic             uses_rt;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
    } slot_t;

endpackage

// File: rtl/lwand_hz_decode.sv
// Module: lwand_hz_decode
// Turns the fetch/decode instruction word into a hazard record.
// Assumes the opcode occupies the top six bits and three register
// fields follow it; unrecognised words become an empty record.
module lwand_hz_decode
    import lwand_hz_pkg::*;
#(
    parameter int         INSTR_W  = 32,
    parameter logic [5:0] OPC_LOAD = 6'b100011,
    parameter logic [5:0] OPC_REG  = 6'b000000,
    parameter logic [5:0] FN_AND   = 6'b100100
) (
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    output slot_t              slot_o
);
    localparam int OPC_W  = 6;
    localparam int FN_W   = 6;
    localparam int OPC_LO = INSTR_W - OPC_W;
    localparam int RS_LO  = OPC_LO - REG_W;
    localparam int RT_LO  = RS_LO - REG_W;
    localparam int RD_LO  = RT_LO - REG_W;

    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] f_rs, f_rt, f_rd;
    logic             is_load, is_and;

    // Slice the fields out of the word.
    always_comb begin
        opc  = instr_i[INSTR_W-1 -: OPC_W];
        fn   = instr_i[FN_W-1:0];
        f_rs = instr_i[RS_LO +: REG_W];
        f_rt = instr_i[RT_LO +: REG_W];
        f_rd = instr_i[RD_LO +: REG_W];
    end

    // Classify and build the record; anything else is a bubble.
    always_comb begin
        is_load = valid_i && (opc == OPC_LOAD);
        is_and  = valid_i && (opc == OPC_REG) && (fn == FN_AND);
        slot_o  = '0;
        if (is_load || is_and) begin
            slot_o.valid   = 1'b1;
            slot_o.is_load = is_load;
            slot_o.uses_rt = is_and;
            slot_o.dst     = is_load ? f_rt : f_rd;
            slot_o.rs      = f_rs;
            slot_o.rt      = is_and ? f_rt : '0;
        end
    end
endmodule

// File: rtl/lwand_hz_track.sv
// Module: lwand_hz_track
// Shadow of the execute, memory and write-back stage records.
// Assumes the datapath advances every cycle; a stall only swaps the
// record entering execute for a bubble.
module lwand_hz_track
    import lwand_hz_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stall_i,
    input  slot_t id_slot_i,
    output slot_t ex_o,
    output slot_t mem_o,
    output slot_t wb_o
);
    slot_t stage_q [DEPTH];

    // Execute-stage record: take decode, or a bubble while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n)       stage_q[0] <= '0;
        else if (stall_i) stage_q[0] <= '0;
        else              stage_q[0] <= id_slot_i;
    end

    // Later stages: plain shift of the previous record.
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign ex_o  = stage_q[0];
    assign mem_o = stage_q[1];
    assign wb_o  = stage_q[DEPTH-1];

    // R9: a stall leaves execute empty in the following cycle.
    p_bubble_after_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> !ex_o.valid);
    // R1: the write-back record follows the memory record by one cycle.
    p_wb_follows_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_o.valid |=> !wb_o.valid);
endmodule

// File: rtl/lwand_hz_fwd.sv
// Module: lwand_hz_fwd
// Chooses the source of one execute-stage ALU operand.
// Assumes only an AND result is ready in the memory stage, while any
// write-back value is ready.
module lwand_hz_fwd
    import lwand_hz_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             need_i,
    input  logic [REG_W-1:0] src_i,
    input  slot_t            mem_i,
    input  slot_t            wb_i,
    output fwd_src_e         sel_o
);
    logic hit_mem, hit_wb;

    // Compare the source with each older destination.
    always_comb begin
        hit_mem = need_i && mem_i.valid && !mem_i.is_load &&
                  (mem_i.dst != '0) && (mem_i.dst == src_i);
        hit_wb  = need_i && wb_i.valid &&
                  (wb_i.dst != '0) && (wb_i.dst == src_i);
    end

    // The younger producer wins.
    always_comb begin
        if (hit_mem)     sel_o = SRC_EXMEM;
        else if (hit_wb) sel_o = SRC_MEMWB;
        else             sel_o = SRC_REGFILE;
    end

    // R3: the memory-stage source is only taken from an AND.
    p_exmem_is_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == SRC_EXMEM) |-> (mem_i.valid && !mem_i.is_load));
    // R4: the write-back source needs a live producer.
    p_memwb_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == SRC_MEMWB) |-> wb_i.valid);
    // R6: register 0 is never forwarded.
    p_no_zero_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o != SRC_REGFILE) |-> (src_i != '0));
    // R2: only the three legal codes appear.
    p_sel_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o != 2'b11);
endmodule

// File: rtl/lwand_hz_stall.sv
// Module: lwand_hz_stall
// Detects a load in execute whose destination the decoded instruction
// reads. Assumes a load reads only rs and an AND reads rs and rt.
module lwand_hz_stall
    import lwand_hz_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t id_i,
    input  slot_t ex_i,
    output logic  stall_o
);
    logic ex_loads, rs_dep, rt_dep;

    // Load-use comparison.
    always_comb begin
        ex_loads = ex_i.valid && ex_i.is_load && (ex_i.dst != '0);
        rs_dep   = id_i.valid && (id_i.rs == ex_i.dst);
        rt_dep   = id_i.valid && id_i.uses_rt && (id_i.rt == ex_i.dst);
        stall_o  = ex_loads && (rs_dep || rt_dep);
    end

    // R8: a stall always has a load in execute.
    p_stall_needs_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (ex_i.valid && ex_i.is_load));
    // R9: a stall never lasts two cycles.
    p_stall_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o);
    // R7: a load in decode stalls only on its rs.
    p_load_rt_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_i.is_load && (id_i.rs != ex_i.dst)) |-> !stall_o);
endmodule

// File: rtl/lwand_hazard_ctrl.sv
// Module: lwand_hazard_ctrl (top)
// Data-hazard controller for a load/AND five-stage pipeline: decodes
// the decode-stage word, tracks the older stages and drives operand
// selects and the load-use stall. Assumes the register file is
// written before it is read within a cycle.
module lwand_hazard_ctrl
    import lwand_hz_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int N_OPND  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ifid_valid,
    input  logic [INSTR_W-1:0] ifid_instr,
    output logic               stall,
    output logic [1:0]         fwd_a_sel,
    output logic [1:0]         fwd_b_sel
);
    slot_t            id_slot, ex_slot, mem_slot, wb_slot;
    logic             stall_w;
    fwd_src_e         sel_w  [N_OPND];
    logic             need_w [N_OPND];
    logic [REG_W-1:0] src_w  [N_OPND];

    lwand_hz_decode #(.INSTR_W(INSTR_W)) u_decode (
        .valid_i (ifid_valid),
        .instr_i (ifid_instr),
        .slot_o  (id_slot)
    );

    lwand_hz_track #(.DEPTH(3)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall_i   (stall_w),
        .id_slot_i (id_slot),
        .ex_o      (ex_slot),
        .mem_o     (mem_slot),
        .wb_o      (wb_slot)
    );

    lwand_hz_stall u_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .id_i    (id_slot),
        .ex_i    (ex_slot),
        .stall_o (stall_w)
    );

    // Operand sources: first is rs for any instruction, second rt for AND only.
    always_comb begin
        need_w[0] = ex_slot.valid;
        src_w[0]  = ex_slot.rs;
        need_w[1] = ex_slot.valid && ex_slot.uses_rt;
        src_w[1]  = ex_slot.rt;
    end

    for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
        lwand_hz_fwd u_fwd (
            .clk    (clk),
            .rst_n  (rst_n),
            .need_i (need_w[k]),
            .src_i  (src_w[k]),
            .mem_i  (mem_slot),
            .wb_i   (wb_slot),
            .sel_o  (sel_w[k])
        );
    end

    assign stall     = stall_w;
    assign fwd_a_sel = sel_w[0];
    assign fwd_b_sel = sel_w[1];

    // R7: a load in execute never takes its second operand from a bypass.
    p_load_second_opnd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_slot.valid && ex_slot.is_load) |-> (fwd_b_sel == 2'b00));
endmodule

// File: tb/lwand_hazard_ctrl_tb.sv
module lwand_hazard_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ifid_valid;
    logic [31:0] ifid_instr;
    logic        stall;
    logic [1:0]  fwd_a_sel, fwd_b_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Model state: index 0 execute, 1 memory, 2 write-back.
    // kind 0 bubble, 1 load, 2 AND.
    int mk [3];
    int md [3];
    int ms [3];
    int mt [3];

    always #2 clk = ~clk;

    lwand_hazard_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ifid_valid (ifid_valid),
        .ifid_instr (ifid_instr),
        .stall      (stall),
        .fwd_a_sel  (fwd_a_sel),
        .fwd_b_sel  (fwd_b_sel)
    );

    function automatic logic [31:0] lw(input int rt, input int rs);
        return {6'b100011, rs[4:0], rt[4:0], 16'h0004};
    endfunction

    function automatic logic [31:0] andr(input int rd, input int rs, input int rt);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'b100100};
    endfunction

    function automatic logic [31:0] junk(input int r);
        return {6'b001000, r[4:0], r[4:0], 16'h0001};
    endfunction

    task automatic check(input string tag, input string note, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, note, act, exp);
        end
    endtask

    function automatic int pick(input bit need, input int src);
        if (!need) return 0;
        if (mk[1] == 2 && md[1] != 0 && md[1] == src) return 2;
        if (mk[2] != 0 && md[2] != 0 && md[2] == src) return 1;
        return 0;
    endfunction

    function automatic string ftag(input bit need, input int src, input int e);
        if (e == 2) return (mk[2] != 0 && md[2] == src) ? "R5" : "R3";
        if (e == 1) return "R4";
        if (need && src == 0) return "R6";
        return "R2";
    endfunction

    task automatic step(input logic v, input logic [31:0] ins, input string note, output bit st);
        int k, d, s, t, ea, eb;
        bit es;
        @(negedge clk);
        ifid_valid = v;
        ifid_instr = ins;
        #1;
        k = 0; d = 0; s = 0; t = 0;
        if (v && ins[31:26] == 6'b100011) begin
            k = 1; d = ins[20:16]; s = ins[25:21];
        end else if (v && ins[31:26] == 6'b0 && ins[5:0] == 6'b100100) begin
            k = 2; d = ins[15:11]; s = ins[25:21]; t = ins[20:16];
        end
        es = (mk[0] == 1) && (md[0] != 0) && (k != 0) &&
             ((s == md[0]) || (k == 2 && t == md[0]));
        ea = pick(mk[0] != 0, ms[0]);
        eb = pick(mk[0] == 2, mt[0]);
        check("R8", {note, " stall"}, int'(stall), int'(es));
        check(ftag(mk[0] != 0, ms[0], ea), {note, " sel_a"}, int'(fwd_a_sel), ea);
        check(ftag(mk[0] == 2, mt[0], eb), {note, " sel_b"}, int'(fwd_b_sel), eb);
        for (int i = 2; i > 0; i--) begin
            mk[i] = mk[i-1]; md[i] = md[i-1]; ms[i] = ms[i-1]; mt[i] = mt[i-1];
        end
        if (es) begin
            mk[0] = 0; md[0] = 0; ms[0] = 0; mt[0] = 0;
        end else begin
            mk[0] = k; md[0] = d; ms[0] = s; mt[0] = t;
        end
        st = es;
    endtask

    task automatic issue(input logic v, input logic [31:0] ins, input string note);
        bit st;
        do step(v, ins, note, st); while (st);
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) issue(1'b0, 32'h0, "drain");
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            mk[i] = 0; md[i] = 0; ms[i] = 0; mt[i] = 0;
        end
        rst_n = 1'b0;
        ifid_valid = 1'b1;
        ifid_instr = lw(1, 2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        ifid_valid = 1'b0;
        rst_n = 1'b1;
        #1;
        // R1: cleared state after reset.
        check("R1", "reset stall", int'(stall), 0);
        check("R1", "reset sel_a", int'(fwd_a_sel), 0);
        check("R1", "reset sel_b", int'(fwd_b_sel), 0);

        // R3: AND feeding the next AND on both operands.
        issue(1, andr(1, 2, 3), "R3 producer");
        issue(1, andr(4, 1, 1), "R3 consumer");
        drain();
        // R4: load two ahead feeding both AND operands.
        issue(1, lw(5, 2), "R4 load");
        issue(1, andr(6, 7, 7), "R4 filler");
        issue(1, andr(8, 5, 5), "R4 consumer");
        drain();
        // R5: both older stages write register 9.
        issue(1, andr(9, 1, 1), "R5 older");
        issue(1, andr(9, 2, 2), "R5 younger");
        issue(1, andr(10, 9, 9), "R5 consumer");
        drain();
        // R6: destination register 0 never stalls or forwards.
        issue(1, lw(0, 1), "R6 load r0");
        issue(1, andr(2, 0, 0), "R6 reader");
        issue(1, andr(3, 0, 0), "R6 reader2");
        drain();
        // R7: load whose rt matches a prior load destination.
        issue(1, lw(5, 1), "R7 load");
        issue(1, lw(5, 2), "R7 rt only");
        drain();
        // R8 and R9: load then AND on rt, then on rs.
        issue(1, lw(6, 1), "R9 load");
        issue(1, andr(3, 2, 6), "R8 R9 rt user");
        issue(1, lw(7, 3), "R9 load2");
        issue(1, lw(4, 7), "R8 R9 rs user");
        drain();
        // Stall and forwarding together: AND -> load base -> AND user.
        issue(1, andr(2, 1, 1), "mix and");
        issue(1, lw(3, 2), "mix load");
        issue(1, andr(1, 3, 2), "mix user");
        drain();
        // R2: unrecognised word and invalid slot are bubbles.
        issue(1, lw(2, 1), "R2 load");
        issue(1, junk(2), "R2 junk");
        issue(0, andr(3, 2, 2), "R2 invalid");
        drain();
        // Random stream over a small register set.
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 9);
            int a = $urandom_range(0, 3);
            int b = $urandom_range(0, 3);
            int c = $urandom_range(0, 3);
            if (r < 4)       issue(1, lw(a, b), "rand");
            else if (r < 8)  issue(1, andr(a, b, c), "rand");
            else if (r == 8) issue(1, junk(a), "rand");
            else             issue(0, andr(a, b, c), "rand");
        end
        drain();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule